// File: doc/BRIEF.md
# Multichannel TDM Serial Transmitter with Refill Requests

This block sends a frame of fixed-width words, one per channel slot, onto a single serial line, slot 0 first and each word most significant bit first, one bit per clock. Software or a DMA engine fills one holding register per slot through a simple write port. At the first clock of each frame, every holding register is copied into its own shift register at once, so the holding registers are free to be rewritten while the frame is on the wire. Frames follow each other without a gap for as long as the run input stays high.

When the final slot of a frame starts to shift, the block raises a transmit refill request. A DMA engine answers it with consecutive writes to holding registers 0 through N-1. A slot marked unused in the control register still takes a write, usually a dummy word, but it is sent as all zeros. The request drops when the write to the highest holding register is accepted, or at the end of the frame, whichever comes first. If a frame starts while some holding register has not been rewritten since the previous load, the old word is sent again and a frame-error flag is raised. Three sticky flags (frame error, receive, transmit) are cleared by writing ones to a status address. A receive request is only an input gated by an enable bit.

Top module: `tdm_tx_dma`

## Requirements
- R1: After reset, serialOut, txDmaReq, rxDmaReq, irq and all three intFlags bits are 0, and no frame runs.
- R2: With txRun high while idle, a frame starts at the next clock edge; from the following cycle serialOut carries slot 0 to slot NUM_SLOTS-1, each word MSB first, one bit per cycle. A new frame follows with no gap while txRun is high at the last bit; otherwise serialOut returns to 0.
- R3: The control register (address NUM_SLOTS) bits [NUM_SLOTS-1:0] mark slots in use; a slot whose bit is 0 is sent as WORD_W zeros, whatever its holding register holds.
- R4: Holding register i (address i, data bits [WORD_W-1:0]) written during a frame does not change the bits of that frame; the next frame sends the new word.
- R5: Control bit 14 gates txDmaReq and control bit 15 gates rxDmaReq; with a bit at 0 the matching request stays low.
- R6: txDmaReq is low during slots 0 to NUM_SLOTS-2 and rises with the first bit of the last slot of each frame (when bit 14 is set).
- R7: txDmaReq falls in the cycle after a write to holding register NUM_SLOTS-1 is accepted, or at the end of the frame, whichever is first; writes to lower holding registers do not lower it.
- R8: intFlags[2] (transmit) is set at the point where the transmit request would rise, whether or not bit 14 is set, and stays set until cleared; irq is the OR of the three flags.
- R9: intFlags[0] (frame error) is set when a frame starts and some holding register has not been written since the previous frame load.
- R10: Writing the status address (NUM_SLOTS+1) clears frame error for data bit 1, receive for bit 2 and transmit for bit 4; other bits have no effect.
- R11: rxDmaReq equals rxReady AND control bit 15; intFlags[1] (receive) is set in each cycle rxReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | ADDR_W | Write address: holding registers, control, status |
| wrData | input | 16 | Write data |
| txRun | input | 1 | Keep frames running |
| rxReady | input | 1 | Receive side has data |
| serialOut | output | 1 | Serial frame output |
| txDmaReq | output | 1 | Transmit refill request |
| rxDmaReq | output | 1 | Gated receive request |
| intFlags | output | 3 | {transmit, receive, frame error} sticky flags |
| irq | output | 1 | OR of the flags |

## Verification
The hardest state to reach is a frame that starts with only part of the holding registers refilled, because it needs a refill that lowers the request early without touching the middle slots. The bench drives the refill writes inside the last slot, cycle by cycle, in one frame writing all slots, in the next writing only slot 0 and the last slot, so the following frame carries two stale words and must flag a frame error. A later run with the enable bit cleared and a slot marked unused checks that the flag still rises, the request stays low and the unused slot is sent as zeros.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  localparam int DATA_W      = 16;
  localparam int DMA_TX_BIT  = 14;
  localparam int DMA_RX_BIT  = 15;
  localparam int CLR_FERR    = 1;
  localparam int CLR_RX      = 2;
  localparam int CLR_TX      = 4;

  typedef struct packed {
    logic loadAll;
    logic shiftOn;
  } txStrobes_t;
endpackage

// File: rtl/tdm_tx_ctrl.sv
module tdm_tx_ctrl
  import tdm_tx_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int WORD_W    = 8,
  parameter int ADDR_W    = 4,
  parameter int SLOT_W    = 2,
  parameter int BIT_W     = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 txRun,
  input  logic                 rxReady,
  output txStrobes_t           strb,
  output logic [NUM_SLOTS-1:0] holdWe,
  output logic [NUM_SLOTS-1:0] cfgMask,
  output logic [SLOT_W-1:0]    slotIdx,
  output logic [BIT_W-1:0]     bitIdx,
  output logic                 running,
  output logic [1:0]           dmaEn,
  output logic                 txDmaReq,
  output logic                 rxDmaReq,
  output logic [2:0]           intFlags
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_SLOTS);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_SLOTS + 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);
  localparam logic [SLOT_W-1:0] PEN_SLOT  = SLOT_W'((NUM_SLOTS > 1) ? NUM_SLOTS - 2 : 0);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(WORD_W - 1);

  logic ctrlWr, statWr, lastBit, frameEnd, frameStart, enterLast;
  logic refillOpen, ferrFlag, rxFlag, txFlag;
  logic [NUM_SLOTS-1:0] fresh;
  logic unusedData;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_dec
    assign holdWe[g] = wrEn && (wrAddr == ADDR_W'(g));
  end

  assign ctrlWr     = wrEn && (wrAddr == CTRL_ADDR);
  assign statWr     = wrEn && (wrAddr == STAT_ADDR);
  assign lastBit    = (bitIdx == LAST_BIT);
  assign frameEnd   = running && lastBit && (slotIdx == LAST_SLOT);
  assign frameStart = txRun && (!running || frameEnd);
  assign enterLast  = (NUM_SLOTS == 1) ? frameStart
                                       : (running && lastBit && (slotIdx == PEN_SLOT));
  assign unusedData = ^wrData;

  // Slot and bit position counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      slotIdx <= '0;
      bitIdx  <= '0;
    end else if (frameStart) begin
      running <= 1'b1;
      slotIdx <= '0;
      bitIdx  <= '0;
    end else if (frameEnd) begin
      running <= 1'b0;
      slotIdx <= '0;
      bitIdx  <= '0;
    end else if (running) begin
      if (lastBit) begin
        bitIdx  <= '0;
        slotIdx <= slotIdx + 1'b1;
      end else begin
        bitIdx <= bitIdx + 1'b1;
      end
    end
  end

  // Refill window: opens with the last slot, closes on the top write or frame end
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refillOpen <= 1'b0;
    end else if (enterLast) begin
      refillOpen <= 1'b1;
    end else if (frameStart || frameEnd || holdWe[NUM_SLOTS-1]) begin
      refillOpen <= 1'b0;
    end
  end

  // Rewrite tracking since the previous load
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fresh <= '0;
    end else if (frameStart) begin
      fresh <= holdWe;
    end else begin
      fresh <= fresh | holdWe;
    end
  end

  // Configuration
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dmaEn   <= 2'b00;
      cfgMask <= '1;
    end else if (ctrlWr) begin
      dmaEn   <= {wrData[DMA_RX_BIT], wrData[DMA_TX_BIT]};
      cfgMask <= wrData[NUM_SLOTS-1:0];
    end
  end

  // Sticky flags, set has priority over clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ferrFlag <= 1'b0;
      rxFlag   <= 1'b0;
      txFlag   <= 1'b0;
    end else begin
      if (frameStart && !(&fresh))        ferrFlag <= 1'b1;
      else if (statWr && wrData[CLR_FERR]) ferrFlag <= 1'b0;
      if (rxReady)                        rxFlag <= 1'b1;
      else if (statWr && wrData[CLR_RX])  rxFlag <= 1'b0;
      if (enterLast)                      txFlag <= 1'b1;
      else if (statWr && wrData[CLR_TX])  txFlag <= 1'b0;
    end
  end

  assign strb.loadAll = frameStart;
  assign strb.shiftOn = running;
  assign txDmaReq     = refillOpen && dmaEn[0];
  assign rxDmaReq     = rxReady && dmaEn[1];
  assign intFlags     = {txFlag, rxFlag, ferrFlag};
endmodule

// File: rtl/tdm_tx_datapath.sv
module tdm_tx_datapath
  import tdm_tx_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int WORD_W    = 8,
  parameter int SLOT_W    = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  txStrobes_t           strb,
  input  logic [NUM_SLOTS-1:0] holdWe,
  input  logic [WORD_W-1:0]    wrWord,
  input  logic [NUM_SLOTS-1:0] cfgMask,
  input  logic [SLOT_W-1:0]    slotIdx,
  output logic                 serialOut
);
  logic [NUM_SLOTS-1:0] msbVec;
  logic [NUM_SLOTS-1:0] frameMask;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic [WORD_W-1:0] holdQ;
    logic [WORD_W-1:0] shiftQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        holdQ  <= '0;
        shiftQ <= '0;
      end else begin
        if (holdWe[g]) holdQ <= wrWord;
        if (strb.loadAll) begin
          shiftQ <= holdQ;
        end else if (strb.shiftOn && (slotIdx == SLOT_W'(g))) begin
          shiftQ <= {shiftQ[WORD_W-2:0], 1'b0};
        end
      end
    end

    assign msbVec[g] = shiftQ[WORD_W-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN)             frameMask <= '0;
    else if (strb.loadAll) frameMask <= cfgMask;
  end

  assign serialOut = strb.shiftOn && frameMask[slotIdx] && msbVec[slotIdx];
endmodule

// File: rtl/tdm_tx_dma.sv
module tdm_tx_dma
  import tdm_tx_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int WORD_W    = 8,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [15:0]       wrData,
  input  logic              txRun,
  input  logic              rxReady,
  output logic              serialOut,
  output logic              txDmaReq,
  output logic              rxDmaReq,
  output logic [2:0]        intFlags,
  output logic              irq
);
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int BIT_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  txStrobes_t           strb;
  logic [NUM_SLOTS-1:0] holdWe, cfgMask;
  logic [SLOT_W-1:0]    slotIdx;
  logic [BIT_W-1:0]     bitIdx;
  logic                 running;
  logic [1:0]           dmaEn;

  tdm_tx_ctrl #(
    .NUM_SLOTS(NUM_SLOTS), .WORD_W(WORD_W), .ADDR_W(ADDR_W),
    .SLOT_W(SLOT_W), .BIT_W(BIT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .txRun(txRun), .rxReady(rxReady), .strb(strb), .holdWe(holdWe),
    .cfgMask(cfgMask), .slotIdx(slotIdx), .bitIdx(bitIdx), .running(running),
    .dmaEn(dmaEn), .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq), .intFlags(intFlags)
  );

  tdm_tx_datapath #(
    .NUM_SLOTS(NUM_SLOTS), .WORD_W(WORD_W), .SLOT_W(SLOT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .holdWe(holdWe),
    .wrWord(wrData[WORD_W-1:0]), .cfgMask(cfgMask), .slotIdx(slotIdx),
    .serialOut(serialOut)
  );

  assign irq = |intFlags;
endmodule

// File: rtl/tdm_tx_dma_chk.sv
module tdm_tx_dma_chk #(
  parameter int NUM_SLOTS = 4,
  parameter int WORD_W    = 8,
  parameter int ADDR_W    = 4,
  parameter int SLOT_W    = 2,
  parameter int BIT_W     = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [15:0]       wrData,
  input logic              serialOut,
  input logic              txDmaReq,
  input logic [2:0]        intFlags,
  input logic              running,
  input logic              loadAll,
  input logic [SLOT_W-1:0] slotIdx,
  input logic [BIT_W-1:0]  bitIdx,
  input logic [1:0]        dmaEn
);
  localparam logic [ADDR_W-1:0] TOP_ADDR  = ADDR_W'(NUM_SLOTS - 1);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_SLOTS + 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(WORD_W - 1);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> !serialOut);

  a_r5_req_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    txDmaReq |-> dmaEn[0]);

  a_r6_req_in_last_slot: assert property (@(posedge clk) disable iff (!rstN)
    txDmaReq |-> (running && slotIdx == LAST_SLOT));

  a_r7_drop_after_top_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == TOP_ADDR && running && slotIdx == LAST_SLOT && bitIdx != LAST_BIT)
      |=> !txDmaReq);

  a_r8_tx_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (intFlags[2] && !(wrEn && wrAddr == STAT_ADDR && wrData[4])) |=> intFlags[2]);

  a_r10_ferr_clear: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == STAT_ADDR && wrData[1] && !loadAll) |=> !intFlags[0]);
endmodule

bind tdm_tx_dma tdm_tx_dma_chk #(
  .NUM_SLOTS(NUM_SLOTS), .WORD_W(WORD_W), .ADDR_W(ADDR_W),
  .SLOT_W(SLOT_W), .BIT_W(BIT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .serialOut(serialOut), .txDmaReq(txDmaReq), .intFlags(intFlags),
  .running(running), .loadAll(strb.loadAll), .slotIdx(slotIdx),
  .bitIdx(bitIdx), .dmaEn(dmaEn)
);

// File: tb/tdm_tx_dma_tb.sv
module tdm_tx_dma_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic       txRun = 1'b0;
  logic       rxReady = 1'b0;
  logic       serialOut, txDmaReq, rxDmaReq, irq;
  logic [2:0] intFlags;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  tdm_tx_dma #(.NUM_SLOTS(4), .WORD_W(8), .ADDR_W(4)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .txRun(txRun), .rxReady(rxReady), .serialOut(serialOut),
    .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq), .intFlags(intFlags), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // One 32-cycle frame; refill writes start in the last slot
  task automatic frameRun(input logic [31:0] expStream, input int nWr,
                          input logic [15:0] wrAddrs, input logic [31:0] wrVals,
                          input bit dmaOn, input bit expFerr, input string stag);
    bit topDone = 1'b0;
    int wi = 0;
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      chk(serialOut == expStream[31-k], stag, {31'd0, serialOut}, {31'd0, expStream[31-k]});
      if (k < 24)
        chk(txDmaReq == 1'b0, "R6 low before last slot", {31'd0, txDmaReq}, 32'd0);
      else if (!dmaOn)
        chk(txDmaReq == 1'b0, "R5 tx request gated", {31'd0, txDmaReq}, 32'd0);
      else
        chk(txDmaReq == !topDone, "R7 request window", {31'd0, txDmaReq}, {31'd0, !topDone});
      if (k == 0)
        chk(intFlags[0] == expFerr, "R9 frame error at start", {31'd0, intFlags[0]}, {31'd0, expFerr});
      if (k == 24) begin
        chk(intFlags[2] == 1'b1, "R8 tx flag set", {31'd0, intFlags[2]}, 32'd1);
        chk(irq == 1'b1, "R8 irq", {31'd0, irq}, 32'd1);
      end
      wrEn = 1'b0;
      if (k >= 24 && wi < nWr) begin
        wrEn   = 1'b1;
        wrAddr = wrAddrs[15-4*wi -: 4];
        wrData = {8'h00, wrVals[31-8*wi -: 8]};
        if (wrAddr == 4'd3) topDone = 1'b1;
        wi++;
      end
    end
  endtask

  task automatic testReset();
    chk(serialOut == 0 && txDmaReq == 0 && rxDmaReq == 0 && irq == 0 && intFlags == 0,
        "R1 reset state", {27'd0, serialOut, txDmaReq, rxDmaReq, irq, 1'b0} | {29'd0, intFlags}, 32'd0);
  endtask

  task automatic testRx();
    busWrite(4'd4, 16'h400F);
    rxReady = 1'b1; #1;
    chk(rxDmaReq == 1'b0, "R11 rx request gated off", {31'd0, rxDmaReq}, 32'd0);
    @(negedge clk);
    rxReady = 1'b0;
    chk(intFlags[1] == 1'b1, "R11 rx flag set", {29'd0, intFlags}, 32'd2);
    busWrite(4'd4, 16'hC00F);
    rxReady = 1'b1; #1;
    chk(rxDmaReq == 1'b1, "R11 rx request enabled", {31'd0, rxDmaReq}, 32'd1);
    @(negedge clk);
    rxReady = 1'b0;
    busWrite(4'd4, 16'h400F);
  endtask

  task automatic testStream();
    busWrite(4'd0, 16'h00A5);
    busWrite(4'd1, 16'h003C);
    busWrite(4'd2, 16'h00F0);
    busWrite(4'd3, 16'h0081);
    txRun = 1'b1;
    frameRun(32'hA53CF081, 4, 16'h0123, 32'h11223344, 1'b1, 1'b0, "R2 first frame");
    frameRun(32'h11223344, 2, 16'h0300, 32'h55660000, 1'b1, 1'b0, "R4 refilled frame");
    frameRun(32'h55223366, 0, 16'h0000, 32'h00000000, 1'b1, 1'b1, "R9 stale words resent");
    txRun = 1'b0;
    @(negedge clk);
    chk(txDmaReq == 1'b0, "R7 request drops at frame end", {31'd0, txDmaReq}, 32'd0);
    for (int i = 0; i < 6; i++) begin
      chk(serialOut == 1'b0, "R2 idle after stop", {31'd0, serialOut}, 32'd0);
      @(negedge clk);
    end
  endtask

  task automatic testClear();
    chk(intFlags == 3'b111, "R10 flags before clear", {29'd0, intFlags}, 32'd7);
    busWrite(4'd5, 16'h0008);
    chk(intFlags == 3'b111, "R10 unrelated bit ignored", {29'd0, intFlags}, 32'd7);
    busWrite(4'd5, 16'h0002);
    chk(intFlags == 3'b110, "R10 frame error cleared", {29'd0, intFlags}, 32'd6);
    busWrite(4'd5, 16'h0014);
    chk(intFlags == 3'b000, "R10 rx and tx cleared", {29'd0, intFlags}, 32'd0);
    chk(irq == 1'b0, "R8 irq low when clear", {31'd0, irq}, 32'd0);
  endtask

  task automatic testUnusedSlot();
    busWrite(4'd4, 16'h000B);
    busWrite(4'd0, 16'h0077);
    busWrite(4'd1, 16'h0088);
    busWrite(4'd2, 16'h0099);
    busWrite(4'd3, 16'h00AA);
    txRun = 1'b1;
    frameRun(32'h778800AA, 4, 16'h0123, 32'h01020304, 1'b0, 1'b0, "R3 unused slot zeros");
    frameRun(32'h01020004, 0, 16'h0000, 32'h00000000, 1'b0, 1'b0, "R3 dummy slot zeros");
    txRun = 1'b0;
    @(negedge clk);
    chk(serialOut == 1'b0 && txDmaReq == 1'b0, "R2 stopped", {30'd0, serialOut, txDmaReq}, 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRx();
    testStream();
    testClear();
    testUnusedSlot();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule